// File: doc/BRIEF.md
# PF/VF Doorbell Mailbox Bank

This block is a bank of 32-bit mailbox words. One host-side requester (the PF port) uses it to swap short messages with `NUM_VF` guest-side requesters (the VF ports). The PF port can read and write the word of any VF, chosen by index. Each VF port reaches only the word that belongs to it. Inside each 16-bit message half, bit 0 is the doorbell and bit 1 is the origin flag. A doorbell counts only when both bits are 1. While a live doorbell is held, a level interrupt goes to the receiving side. The receiver acknowledges by writing the doorbell bit back to 0. The sender sees that clear when it reads the word back.

The `SPLIT` parameter chooses between two layouts. With `SPLIT=0` there is one shared word per VF. Bits [15:0] carry host-to-guest traffic and bits [31:16] carry guest-to-host traffic. With `SPLIT=1` each VF has two words, picked by a direction bit (0 = host-to-guest, 1 = guest-to-host). Each of those words uses bit 0 as the doorbell and bit 1 as the origin. The block gives no meaning to the message type or data bits.

Each word chooses its next value from the write sources present in a cycle:
- **SRC_NONE**: the word holds its value.
- **SRC_PF**: the PF data is loaded.
- **SRC_VF**: the VF data is loaded.
- **SRC_BOTH**: the two writes are merged by half (shared mode), or the owner of that direction wins (split mode).

Reads are combinational. Writes take effect at the clock edge where they are presented.

Top module: `mbox_bank`

## Requirements
- R1: After reset every mailbox word reads 0 and `vf_irq`, `pf_pending` and `pf_irq` are all 0.
- R2: A PF write with `pf_idx` below `NUM_VF` stores `pf_wdata` at the clock edge where it is presented (shared mode: whole word). From the next cycle `pf_rdata` returns the stored word for that index (and, in split mode, for that direction).
- R3: A VF port whose index field is not its own port number has its write dropped, and its `vf_rdata` slice reads 0.
- R4: `vf_irq[i]` is high exactly while bit 0 and bit 1 of VF i's host-to-guest half (shared: bits [1:0]; split: word 0 bits [1:0]) are both 1.
- R5: `pf_pending[i]` is high exactly while the guest-to-host doorbell and origin of VF i are both 1 (shared: bits [17:16]; split: word 1 bits [1:0]). `pf_irq` is the OR of `pf_pending`, and it can rise only in the cycle after some write.
- R6: A doorbell bit written with origin bit 0 raises no interrupt.
- R7: Writing the doorbell bit to 0 drops the matching interrupt in the next cycle, and the sender then reads the bit as 0.
- R8: In shared mode, when the PF and the owning VF write the same word in one cycle, the result is {VF data [31:16], PF data [15:0]}.
- R9: In split mode the direction bit picks the word (0 = host-to-guest, 1 = guest-to-host). A guest-to-host doorbell sets `pf_pending` but not `vf_irq`.
- R10: In split mode, for same-cycle writes to one word: the PF wins word 0 and the VF wins word 1.
- R11: A PF write with `pf_idx` at or above `NUM_VF` changes no word. A PF read of such an index returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pf_wr_en | input | 1 | PF write strobe |
| pf_idx | input | IW | PF target VF index (read and write) |
| pf_dir | input | 1 | PF word select in split mode (0 host-to-guest, 1 guest-to-host) |
| pf_wdata | input | 32 | PF write data |
| pf_rdata | output | 32 | PF read data for `pf_idx`/`pf_dir` |
| vf_wr_en | input | NUM_VF | Per-VF write strobe |
| vf_idx | input | NUM_VF*IW | Per-VF index field; must equal the port number |
| vf_dir | input | NUM_VF | Per-VF word select in split mode |
| vf_wdata | input | NUM_VF*32 | Per-VF write data |
| vf_rdata | output | NUM_VF*32 | Per-VF read data |
| vf_irq | output | NUM_VF | Level interrupt to each VF |
| pf_pending | output | NUM_VF | Per-VF pending guest-to-host doorbells |
| pf_irq | output | 1 | Level interrupt to the PF |

## Verification
Every write lands at the rising edge where it is presented. Stored words and both interrupt kinds are therefore due at that edge, one cycle after the inputs are driven. Read data is combinational from the current index and direction, so it is due in the same cycle the index is applied. The bench drives inputs on the falling edge and lets a behavioural model take the same writes at the rising edge. Two time units after that edge it compares every output of a shared-mode and a split-mode instance. Directed checks set read indices after the falling edge and sample one time unit later.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
    localparam int WORD_W     = 32;
    localparam int HALF_W     = 16;
    localparam int DB_BIT     = 0;
    localparam int ORIGIN_BIT = 1;

    typedef enum logic [1:0] {
        SRC_NONE = 2'b00,
        SRC_PF   = 2'b01,
        SRC_VF   = 2'b10,
        SRC_BOTH = 2'b11
    } wr_src_e;

    // doorbell counts only when the origin flag marks a valid message
    function automatic logic ring_live(input logic [1:0] lo);
        return lo[DB_BIT] & lo[ORIGIN_BIT];
    endfunction
endpackage

// File: rtl/mbox_word.sv
`timescale 1ns/1ps
module mbox_word import mbox_pkg::*; #(
    parameter bit SPLIT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pf_we,
    input  logic              pf_dir,
    input  logic [WORD_W-1:0] pf_wdata,
    input  logic              vf_we,
    input  logic              vf_dir,
    input  logic [WORD_W-1:0] vf_wdata,
    output logic [WORD_W-1:0] to_vf_word,
    output logic [WORD_W-1:0] to_pf_word,
    output logic              irq_vf,
    output logic              pend_pf
);
    generate
        if (!SPLIT) begin : g_shared
            logic [WORD_W-1:0] word_q;
            wr_src_e           src;
            logic              dir_unused;

            assign dir_unused = pf_dir ^ vf_dir;
            assign src        = wr_src_e'({vf_we, pf_we});

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else begin
                    unique case (src)
                        SRC_NONE: word_q <= word_q;
                        SRC_PF:   word_q <= pf_wdata;
                        SRC_VF:   word_q <= vf_wdata;
                        SRC_BOTH: word_q <= {vf_wdata[WORD_W-1:HALF_W], pf_wdata[HALF_W-1:0]};
                        default:  word_q <= word_q;
                    endcase
                end
            end

            always_comb begin
                to_vf_word = word_q;
                to_pf_word = word_q;
                irq_vf     = ring_live(word_q[1:0]);
                pend_pf    = ring_live(word_q[HALF_W+1:HALF_W]);
            end

            a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
                (!pf_we && !vf_we) |=> $stable(word_q));
            a_r8_merge_by_half: assert property (@(posedge clk) disable iff (!rst_n)
                (pf_we && vf_we) |=> (to_vf_word == {$past(vf_wdata[WORD_W-1:HALF_W]), $past(pf_wdata[HALF_W-1:0])}));
            a_r6_origin_gate: assert property (@(posedge clk) disable iff (!rst_n)
                (pf_we && !vf_we && !pf_wdata[ORIGIN_BIT]) |=> !irq_vf);
        end else begin : g_split
            logic [WORD_W-1:0] tv_q;
            logic [WORD_W-1:0] tp_q;
            wr_src_e           src_tv;
            wr_src_e           src_tp;

            assign src_tv = wr_src_e'({vf_we && !vf_dir, pf_we && !pf_dir});
            assign src_tp = wr_src_e'({vf_we &&  vf_dir, pf_we &&  pf_dir});

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tv_q <= '0;
                end else begin
                    unique case (src_tv)
                        SRC_NONE: tv_q <= tv_q;
                        SRC_PF:   tv_q <= pf_wdata;
                        SRC_VF:   tv_q <= vf_wdata;
                        SRC_BOTH: tv_q <= pf_wdata;
                        default:  tv_q <= tv_q;
                    endcase
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tp_q <= '0;
                end else begin
                    unique case (src_tp)
                        SRC_NONE: tp_q <= tp_q;
                        SRC_PF:   tp_q <= pf_wdata;
                        SRC_VF:   tp_q <= vf_wdata;
                        SRC_BOTH: tp_q <= vf_wdata;
                        default:  tp_q <= tp_q;
                    endcase
                end
            end

            always_comb begin
                to_vf_word = tv_q;
                to_pf_word = tp_q;
                irq_vf     = ring_live(tv_q[1:0]);
                pend_pf    = ring_live(tp_q[1:0]);
            end

            a_r10_host_word_pf_wins: assert property (@(posedge clk) disable iff (!rst_n)
                (pf_we && !pf_dir && vf_we && !vf_dir) |=> (to_vf_word == $past(pf_wdata)));
            a_r10_guest_word_vf_wins: assert property (@(posedge clk) disable iff (!rst_n)
                (pf_we && pf_dir && vf_we && vf_dir) |=> (to_pf_word == $past(vf_wdata)));
            a_r9_guest_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (!(pf_we && pf_dir) && !(vf_we && vf_dir)) |=> $stable(to_pf_word));
        end
    endgenerate
endmodule

// File: rtl/mbox_rdsel.sv
`timescale 1ns/1ps
module mbox_rdsel import mbox_pkg::*; #(
    parameter int NUM_VF = 5,
    parameter int IW     = 3
) (
    input  logic [NUM_VF*WORD_W-1:0] tv_words,
    input  logic [NUM_VF*WORD_W-1:0] tp_words,
    input  logic [IW-1:0]            idx,
    input  logic                     dir,
    input  logic                     allow,
    output logic [WORD_W-1:0]        rdata
);
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_VF; k++) begin
            if (allow && (idx == IW'(k))) begin
                rdata = dir ? tp_words[k*WORD_W +: WORD_W] : tv_words[k*WORD_W +: WORD_W];
            end
        end
    end
endmodule

// File: rtl/mbox_bank.sv
`timescale 1ns/1ps
module mbox_bank import mbox_pkg::*; #(
    parameter int NUM_VF = 5,
    parameter bit SPLIT  = 1'b0,
    localparam int IW    = (NUM_VF > 1) ? $clog2(NUM_VF) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pf_wr_en,
    input  logic [IW-1:0]            pf_idx,
    input  logic                     pf_dir,
    input  logic [WORD_W-1:0]        pf_wdata,
    output logic [WORD_W-1:0]        pf_rdata,
    input  logic [NUM_VF-1:0]        vf_wr_en,
    input  logic [NUM_VF*IW-1:0]     vf_idx,
    input  logic [NUM_VF-1:0]        vf_dir,
    input  logic [NUM_VF*WORD_W-1:0] vf_wdata,
    output logic [NUM_VF*WORD_W-1:0] vf_rdata,
    output logic [NUM_VF-1:0]        vf_irq,
    output logic [NUM_VF-1:0]        pf_pending,
    output logic                     pf_irq
);
    logic [NUM_VF*WORD_W-1:0] tv_words;
    logic [NUM_VF*WORD_W-1:0] tp_words;
    logic [NUM_VF-1:0]        pf_hit;
    logic [NUM_VF-1:0]        vf_hit;

    generate
        for (genvar v = 0; v < NUM_VF; v++) begin : g_vf
            assign pf_hit[v] = pf_wr_en && (pf_idx == IW'(v));
            assign vf_hit[v] = vf_wr_en[v] && (vf_idx[v*IW +: IW] == IW'(v));

            mbox_word #(.SPLIT(SPLIT)) u_word (
                .clk        (clk),
                .rst_n      (rst_n),
                .pf_we      (pf_hit[v]),
                .pf_dir     (pf_dir),
                .pf_wdata   (pf_wdata),
                .vf_we      (vf_hit[v]),
                .vf_dir     (vf_dir[v]),
                .vf_wdata   (vf_wdata[v*WORD_W +: WORD_W]),
                .to_vf_word (tv_words[v*WORD_W +: WORD_W]),
                .to_pf_word (tp_words[v*WORD_W +: WORD_W]),
                .irq_vf     (vf_irq[v]),
                .pend_pf    (pf_pending[v])
            );

            mbox_rdsel #(.NUM_VF(NUM_VF), .IW(IW)) u_vf_rd (
                .tv_words (tv_words),
                .tp_words (tp_words),
                .idx      (vf_idx[v*IW +: IW]),
                .dir      (vf_dir[v]),
                .allow    (vf_idx[v*IW +: IW] == IW'(v)),
                .rdata    (vf_rdata[v*WORD_W +: WORD_W])
            );
        end
    endgenerate

    mbox_rdsel #(.NUM_VF(NUM_VF), .IW(IW)) u_pf_rd (
        .tv_words (tv_words),
        .tp_words (tp_words),
        .idx      (pf_idx),
        .dir      (pf_dir),
        .allow    (1'b1),
        .rdata    (pf_rdata)
    );

    assign pf_irq = |pf_pending;

    a_r5_irq_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_irq) |-> $past(pf_wr_en || (|vf_wr_en)));
    a_r11_out_of_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_wr_en && (32'(pf_idx) >= NUM_VF) && (vf_wr_en == '0)) |=> ($stable(pf_pending) && $stable(vf_irq)));
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (pf_irq == 1'b0));
endmodule

// File: tb/mbox_bank_tb_top.sv
`timescale 1ns/1ps
module mbox_bank_tb_top;
    localparam int NV = 5;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              pf_we = 1'b0;
    logic [IW-1:0]     pf_idx = '0;
    logic              pf_dir = 1'b0;
    logic [31:0]       pf_wd = '0;
    logic [NV-1:0]     vf_we = '0;
    logic [NV*IW-1:0]  vf_idx = '0;
    logic [NV-1:0]     vf_dir = '0;
    logic [NV*32-1:0]  vf_wd = '0;

    logic [31:0]       pf_rd_sh, pf_rd_sp;
    logic [NV*32-1:0]  vf_rd_sh, vf_rd_sp;
    logic [NV-1:0]     vf_irq_sh, vf_irq_sp, pend_sh, pend_sp;
    logic              pf_irq_sh, pf_irq_sp;

    mbox_bank #(.NUM_VF(NV), .SPLIT(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .pf_wr_en(pf_we), .pf_idx(pf_idx), .pf_dir(pf_dir),
        .pf_wdata(pf_wd), .pf_rdata(pf_rd_sh), .vf_wr_en(vf_we), .vf_idx(vf_idx),
        .vf_dir(vf_dir), .vf_wdata(vf_wd), .vf_rdata(vf_rd_sh), .vf_irq(vf_irq_sh),
        .pf_pending(pend_sh), .pf_irq(pf_irq_sh));

    mbox_bank #(.NUM_VF(NV), .SPLIT(1'b1)) dut_split_i (
        .clk(clk), .rst_n(rst_n), .pf_wr_en(pf_we), .pf_idx(pf_idx), .pf_dir(pf_dir),
        .pf_wdata(pf_wd), .pf_rdata(pf_rd_sp), .vf_wr_en(vf_we), .vf_idx(vf_idx),
        .vf_dir(vf_dir), .vf_wdata(vf_wd), .vf_rdata(vf_rd_sp), .vf_irq(vf_irq_sp),
        .pf_pending(pend_sp), .pf_irq(pf_irq_sp));

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    // model: [mode 0 shared / 1 split][vf][dir]
    logic [31:0] mdl [2][NV][2];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic live(input logic [31:0] w, input int base);
        return w[base] & w[base+1];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < 2; s++)
                for (int v = 0; v < NV; v++)
                    for (int d = 0; d < 2; d++) mdl[s][v][d] = '0;
        end else begin
            for (int v = 0; v < NV; v++) begin
                bit p, q;
                logic [31:0] vw;
                p  = pf_we && (int'(pf_idx) == v);
                q  = vf_we[v] && (int'(vf_idx[v*IW +: IW]) == v);
                vw = vf_wd[v*32 +: 32];
                if (p && q)  mdl[0][v][0] = {vw[31:16], pf_wd[15:0]};
                else if (p)  mdl[0][v][0] = pf_wd;
                else if (q)  mdl[0][v][0] = vw;
                for (int d = 0; d < 2; d++) begin
                    bit pd, qd;
                    pd = p && (int'(pf_dir) == d);
                    qd = q && (int'(vf_dir[v]) == d);
                    if (pd && qd)  mdl[1][v][d] = (d == 0) ? pf_wd : vw;
                    else if (pd)   mdl[1][v][d] = pf_wd;
                    else if (qd)   mdl[1][v][d] = vw;
                end
            end
        end
        #2;
        if (rst_n && !finished) begin
            for (int s = 0; s < 2; s++) begin
                logic [31:0] e_pf;
                logic [NV-1:0] e_irq, e_pend;
                e_pf = (int'(pf_idx) < NV) ? mdl[s][int'(pf_idx)][(s == 1) ? int'(pf_dir) : 0] : 32'h0;
                chk("R2 pf_rdata", (s == 0) ? pf_rd_sh : pf_rd_sp, e_pf);
                for (int v = 0; v < NV; v++) begin
                    logic [31:0] e_v;
                    e_v = (int'(vf_idx[v*IW +: IW]) == v) ? mdl[s][v][(s == 1) ? int'(vf_dir[v]) : 0] : 32'h0;
                    chk("R3 vf_rdata", (s == 0) ? vf_rd_sh[v*32 +: 32] : vf_rd_sp[v*32 +: 32], e_v);
                    e_irq[v]  = live(mdl[s][v][0], 0);
                    e_pend[v] = (s == 0) ? live(mdl[s][v][0], 16) : live(mdl[s][v][1], 0);
                end
                chk("R4 vf_irq", 32'((s == 0) ? vf_irq_sh : vf_irq_sp), 32'(e_irq));
                chk("R5 pf_pending", 32'((s == 0) ? pend_sh : pend_sp), 32'(e_pend));
                chk("R5 pf_irq", 32'((s == 0) ? pf_irq_sh : pf_irq_sp), 32'(|e_pend));
            end
        end
    end

    task automatic pf_wr(input int idx, input bit dir, input logic [31:0] d);
        @(negedge clk);
        pf_we = 1'b1; pf_idx = IW'(idx); pf_dir = dir; pf_wd = d;
        @(negedge clk);
        pf_we = 1'b0;
    endtask

    task automatic vf_wr(input int v, input int idx, input bit dir, input logic [31:0] d);
        @(negedge clk);
        vf_we[v] = 1'b1; vf_idx[v*IW +: IW] = IW'(idx); vf_dir[v] = dir; vf_wd[v*32 +: 32] = d;
        @(negedge clk);
        vf_we[v] = 1'b0;
    endtask

    task automatic both_wr(input int v, input bit dir, input logic [31:0] pd, input logic [31:0] vd);
        @(negedge clk);
        pf_we = 1'b1; pf_idx = IW'(v); pf_dir = dir; pf_wd = pd;
        vf_we[v] = 1'b1; vf_idx[v*IW +: IW] = IW'(v); vf_dir[v] = dir; vf_wd[v*32 +: 32] = vd;
        @(negedge clk);
        pf_we = 1'b0; vf_we[v] = 1'b0;
    endtask

    task automatic peek(input int idx, input bit dir);
        pf_idx = IW'(idx); pf_dir = dir;
        #1;
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        finished = 1'b1;
        summary();
    end

    initial begin
        for (int v = 0; v < NV; v++) vf_idx[v*IW +: IW] = IW'(v);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset pf_irq sh", 32'(pf_irq_sh), 32'h0);
        chk("R1 reset pf_irq sp", 32'(pf_irq_sp), 32'h0);
        chk("R1 reset vf_irq", 32'({vf_irq_sh, vf_irq_sp}), 32'h0);
        peek(0, 1'b0);
        chk("R1 reset word", pf_rd_sh | pf_rd_sp, 32'h0);

        pf_wr(2, 1'b0, 32'h0000_1233);
        peek(2, 1'b0);
        chk("R2 write sh", pf_rd_sh, 32'h0000_1233);
        chk("R2 write sp", pf_rd_sp, 32'h0000_1233);
        chk("R4 doorbell sh", 32'(vf_irq_sh[2]), 32'h1);
        chk("R4 doorbell sp", 32'(vf_irq_sp[2]), 32'h1);

        pf_wr(1, 1'b0, 32'h0000_0051);
        chk("R6 no origin sh", 32'(vf_irq_sh[1]), 32'h0);
        chk("R6 no origin sp", 32'(vf_irq_sp[1]), 32'h0);

        vf_wr(2, 2, 1'b0, 32'h0000_1232);
        chk("R7 ack irq sh", 32'(vf_irq_sh[2]), 32'h0);
        chk("R7 ack irq sp", 32'(vf_irq_sp[2]), 32'h0);
        peek(2, 1'b0);
        chk("R7 sender sees clear", 32'(pf_rd_sh[0] | pf_rd_sp[0]), 32'h0);

        pf_wr(0, 1'b0, 32'hABCD_0000);
        vf_wr(3, 0, 1'b0, 32'h0003_0003);
        peek(0, 1'b0);
        chk("R3 foreign write dropped sh", pf_rd_sh, 32'hABCD_0000);
        chk("R3 foreign write dropped sp", pf_rd_sp, 32'hABCD_0000);
        chk("R3 foreign read zero", vf_rd_sh[3*32 +: 32] | vf_rd_sp[3*32 +: 32], 32'h0);
        chk("R3 own read", vf_rd_sh[0 +: 32], 32'hABCD_0000);
        vf_idx[3*IW +: IW] = IW'(3);

        vf_wr(4, 4, 1'b1, 32'h0003_0003);
        chk("R5 pending sh", 32'(pend_sh[4]), 32'h1);
        chk("R5 pending sp", 32'(pend_sp[4]), 32'h1);
        chk("R5 pf_irq", 32'({pf_irq_sh, pf_irq_sp}), 32'h3);
        chk("R9 guest word no vf_irq sp", 32'(vf_irq_sp[4]), 32'h0);
        chk("R9 shared low half rings sh", 32'(vf_irq_sh[4]), 32'h1);
        peek(4, 1'b0);
        chk("R9 host word untouched sp", pf_rd_sp, 32'h0);

        pf_wr(4, 1'b1, 32'h0);
        chk("R7 pf ack clears", 32'({pf_irq_sh, pf_irq_sp}), 32'h0);

        both_wr(1, 1'b0, 32'h1111_2223, 32'h3333_4444);
        peek(1, 1'b0);
        chk("R8 merge sh", pf_rd_sh, 32'h3333_2223);
        chk("R10 host word pf wins sp", pf_rd_sp, 32'h1111_2223);

        both_wr(1, 1'b1, 32'h5555_0000, 32'h6666_0003);
        peek(1, 1'b1);
        chk("R8 merge sh", pf_rd_sh, 32'h6666_0000);
        chk("R10 guest word vf wins sp", pf_rd_sp, 32'h6666_0003);

        pf_wr(6, 1'b0, 32'hFFFF_FFFF);
        peek(6, 1'b0);
        chk("R11 range read sh", pf_rd_sh, 32'h0);
        chk("R11 range read sp", pf_rd_sp, 32'h0);
        chk("R11 pending sh", 32'(pend_sh), 32'h0);
        chk("R11 pending sp", 32'(pend_sp), 32'h2);
        chk("R11 vf_irq sh", 32'(vf_irq_sh), 32'h0);
        chk("R11 vf_irq sp", 32'(vf_irq_sp), 32'h2);

        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            pf_we  = $urandom_range(0, 1) == 1;
            pf_idx = IW'($urandom_range(0, 7));
            pf_dir = 1'($urandom_range(0, 1));
            pf_wd  = $urandom;
            for (int v = 0; v < NV; v++) begin
                vf_we[v]  = $urandom_range(0, 2) == 0;
                vf_idx[v*IW +: IW] = ($urandom_range(0, 3) == 0) ? IW'($urandom_range(0, 7)) : IW'(v);
                vf_dir[v] = 1'($urandom_range(0, 1));
                vf_wd[v*32 +: 32] = $urandom;
            end
        end
        @(negedge clk);
        pf_we = 1'b0; vf_we = '0;
        @(negedge clk);
        finished = 1'b1;
        summary();
    end
endmodule